// File: doc/BRIEF.md
# PCM Serial Transmit Port with Frame-Sync Width Detection

This block sends one PCM sample per frame as a serial bit stream on a data line that can be released to high impedance. The line is modelled as a data output plus a driver enable. The bit clock and the transmit frame sync arrive as plain levels and are sampled by a fast system clock. The block finds their edges itself, so all of its logic runs in the system clock domain.

The block measures how long each frame-sync pulse lasts, counted in bit-clock periods, and sorts the pulse into one of two kinds. A short pulse starts the driver one bit clock after the sync. A long pulse starts the driver on whichever comes later, the sync rising or the bit clock rising. The driver is released by a different rule in each mode as well. Software-side logic writes the next sample into a holding register with a load strobe. The sample moves into the shift register when the next frame sync rises, so each frame carries the sample written during the previous cycle.

Top module: `pcm_tx_port`

## Requirements
- R1: After reset the driver enable is 0 and the long-mode flag is 0, so the port starts in short mode.
- R2: A frame sends 8 bits, most significant bit first. While the driver is enabled, each new bit appears only after a rising edge of the bit clock.
- R3: In short mode, a frame sync that is high at a bit-clock falling edge makes the next rising edge enable the driver with the most significant bit.
- R4: In short mode, the driver is disabled at the first bit-clock falling edge after the eighth bit has been presented.
- R5: When a frame-sync pulse ends, the long-mode flag becomes 1 if the pulse covered 3 or more bit-clock falling edges. It becomes 0 if the pulse covered 1 or 2. The new mode governs the following frame.
- R6: In long mode, the driver turns on with the most significant bit once both the frame sync and the bit clock are high. If the sync rises while the bit clock is low, the driver stays off until the bit clock rises.
- R7: In long mode, the driver turns off at the later of two events: the bit-clock falling edge after the eighth bit, or the frame sync going low.
- R8: The bits of a frame are the holding-register contents at the rising edge of the frame sync. A load strobe during a frame changes only the next frame.
- R9: In short mode, one frame-sync pulse starts one frame only, even if the pulse stays high for many bit periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bit clock |
| rst | input | 1 | Synchronous active-high reset |
| bclk_in | input | 1 | Sampled bit clock level |
| fsync_in | input | 1 | Sampled transmit frame-sync level |
| sample_in | input | 8 | Parallel sample to be sent in the next frame |
| sample_load | input | 1 | Write strobe for the holding register |
| sdata | output | 1 | Serial data, valid while sdata_oe is 1 |
| sdata_oe | output | 1 | Driver enable; 0 means high impedance |
| long_mode | output | 1 | 1 when the last frame-sync pulse was long |

## Verification
On every cycle the assertions check how the driver enable switches on and off. In short mode it may rise only at a bit-clock rising edge and fall only at a falling edge. In long mode it may rise only when both the sync and the bit clock are high, and fall only once the sync is low. The assertions also check that the serial data changes during a frame only after a bit-clock rising edge, and that the mode flag changes only once the sync is low. Only the bench scenarios show the bit order, which frame a sample is sent in, where the driver window falls for each pulse width, and how the mode carries from one frame into the next.

// File: rtl/pcm_tx_pkg.sv
package pcm_tx_pkg;
  typedef enum logic [2:0] {
    TX_IDLE,
    TX_WAIT_S,
    TX_ARM_S,
    TX_ARM_L,
    TX_DRIVE
  } tx_state_t;

  localparam int SIG_BCLK = 0;
  localparam int SIG_FSYNC = 1;
  localparam int SIG_COUNT = 2;
endpackage

// File: rtl/pcm_edge_detect.sv
module pcm_edge_detect #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sig_in,
  output logic level,
  output logic rise,
  output logic fall
);
  logic [STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-1:0], sig_in};
  end

  assign level = chain[STAGES-1];
  assign rise  = chain[STAGES-1] & ~chain[STAGES];
  assign fall  = ~chain[STAGES-1] & chain[STAGES];
endmodule

// File: rtl/pcm_sync_width.sv
module pcm_sync_width #(
  parameter int LONG_MIN = 3,
  parameter int CW = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic bclk_fall,
  input  logic fs_lvl,
  input  logic fs_rise,
  input  logic fs_fall,
  output logic long_mode
);
  localparam logic [CW-1:0] CNT_MAX = '1;
  localparam logic [CW-1:0] LONG_TH = CW'(LONG_MIN);

  logic [CW-1:0] width_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      width_cnt <= '0;
      long_mode <= 1'b0;
    end else begin
      if (fs_rise) begin
        width_cnt <= bclk_fall ? CW'(1) : '0;
      end else if (bclk_fall && fs_lvl && width_cnt != CNT_MAX) begin
        width_cnt <= width_cnt + 1'b1;
      end
      if (fs_fall) long_mode <= (width_cnt >= LONG_TH);
    end
  end

  // R5
  mode_change_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(long_mode) |-> $past(!fs_lvl));
endmodule

// File: rtl/pcm_tx_shifter.sv
module pcm_tx_shifter
  import pcm_tx_pkg::*;
#(
  parameter int BITS = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            bclk_lvl,
  input  logic            bclk_rise,
  input  logic            bclk_fall,
  input  logic            fs_lvl,
  input  logic            fs_rise,
  input  logic            long_mode,
  input  logic [BITS-1:0] sample_in,
  input  logic            sample_load,
  output logic            sdata,
  output logic            sdata_oe
);
  localparam int BCW = $clog2(BITS + 1);
  localparam logic [BCW-1:0] LAST = BCW'(BITS);

  tx_state_t       state;
  logic [BITS-1:0] hold_q;
  logic [BITS-1:0] sreg;
  logic [BCW-1:0]  bit_cnt;
  logic            mode_lat;
  logic            fall_seen;

  always_ff @(posedge clk) begin
    if (rst) hold_q <= '0;
    else if (sample_load) hold_q <= sample_in;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= TX_IDLE;
      sreg      <= '0;
      bit_cnt   <= '0;
      mode_lat  <= 1'b0;
      fall_seen <= 1'b0;
      sdata_oe  <= 1'b0;
    end else begin
      case (state)
        TX_IDLE: begin
          if (fs_rise) begin
            sreg      <= hold_q;
            mode_lat  <= long_mode;
            fall_seen <= 1'b0;
            state     <= long_mode ? TX_ARM_L : TX_WAIT_S;
          end
        end
        TX_WAIT_S: begin
          if (bclk_fall && fs_lvl) state <= TX_ARM_S;
          else if (!fs_lvl)        state <= TX_IDLE;
        end
        TX_ARM_S: begin
          if (bclk_rise) begin
            sdata_oe <= 1'b1;
            bit_cnt  <= BCW'(1);
            state    <= TX_DRIVE;
          end
        end
        TX_ARM_L: begin
          if (fs_lvl && bclk_lvl) begin
            sdata_oe <= 1'b1;
            bit_cnt  <= BCW'(1);
            state    <= TX_DRIVE;
          end else if (!fs_lvl) begin
            state <= TX_IDLE;
          end
        end
        TX_DRIVE: begin
          if (bit_cnt != LAST) begin
            if (bclk_rise) begin
              sreg    <= {sreg[BITS-2:0], 1'b0};
              bit_cnt <= bit_cnt + 1'b1;
            end
          end else if (!mode_lat) begin
            if (bclk_fall) begin
              sdata_oe <= 1'b0;
              state    <= TX_IDLE;
            end
          end else begin
            if (bclk_fall) fall_seen <= 1'b1;
            if ((fall_seen || bclk_fall) && !fs_lvl) begin
              sdata_oe <= 1'b0;
              state    <= TX_IDLE;
            end
          end
        end
        default: state <= TX_IDLE;
      endcase
    end
  end

  assign sdata = sreg[BITS-1];

  // R3
  short_on_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sdata_oe) && !mode_lat |-> $past(bclk_rise));

  // R6
  long_on_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sdata_oe) && mode_lat |-> $past(fs_lvl && bclk_lvl));

  // R4
  short_off_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(sdata_oe) && !mode_lat |-> $past(bclk_fall));

  // R7
  long_off_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(sdata_oe) && mode_lat |-> $past(!fs_lvl));

  // R2
  bit_step_chk: assert property (@(posedge clk) disable iff (rst)
    sdata_oe && $past(sdata_oe) && !$stable(sdata) |-> $past(bclk_rise));
endmodule

// File: rtl/pcm_tx_port.sv
module pcm_tx_port
  import pcm_tx_pkg::*;
#(
  parameter int BITS = 8,
  parameter int SYNC_STAGES = 2,
  parameter int LONG_MIN = 3,
  parameter int WCNT_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            bclk_in,
  input  logic            fsync_in,
  input  logic [BITS-1:0] sample_in,
  input  logic            sample_load,
  output logic            sdata,
  output logic            sdata_oe,
  output logic            long_mode
);
  logic [SIG_COUNT-1:0] raw_in;
  logic [SIG_COUNT-1:0] lvl;
  logic [SIG_COUNT-1:0] rise;
  logic [SIG_COUNT-1:0] fall;

  assign raw_in[SIG_BCLK]  = bclk_in;
  assign raw_in[SIG_FSYNC] = fsync_in;

  for (genvar i = 0; i < SIG_COUNT; i++) begin : g_edge
    pcm_edge_detect #(.STAGES(SYNC_STAGES)) u_edge (
      .clk   (clk),
      .rst   (rst),
      .sig_in(raw_in[i]),
      .level (lvl[i]),
      .rise  (rise[i]),
      .fall  (fall[i])
    );
  end

  pcm_sync_width #(.LONG_MIN(LONG_MIN), .CW(WCNT_W)) u_width (
    .clk      (clk),
    .rst      (rst),
    .bclk_fall(fall[SIG_BCLK]),
    .fs_lvl   (lvl[SIG_FSYNC]),
    .fs_rise  (rise[SIG_FSYNC]),
    .fs_fall  (fall[SIG_FSYNC]),
    .long_mode(long_mode)
  );

  pcm_tx_shifter #(.BITS(BITS)) u_shift (
    .clk        (clk),
    .rst        (rst),
    .bclk_lvl   (lvl[SIG_BCLK]),
    .bclk_rise  (rise[SIG_BCLK]),
    .bclk_fall  (fall[SIG_BCLK]),
    .fs_lvl     (lvl[SIG_FSYNC]),
    .fs_rise    (rise[SIG_FSYNC]),
    .long_mode  (long_mode),
    .sample_in  (sample_in),
    .sample_load(sample_load),
    .sdata      (sdata),
    .sdata_oe   (sdata_oe)
  );
endmodule

// File: tb/sim_pcm_tx_port.sv
module sim_pcm_tx_port;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bclk_in = 1'b0;
  logic fsync_in = 1'b0;
  logic [7:0] sample_in = '0;
  logic sample_load = 1'b0;
  logic sdata, sdata_oe, long_mode;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  bit model_long = 1'b0;

  always #10 clk = ~clk;

  pcm_tx_port u0 (
    .clk(clk), .rst(rst), .bclk_in(bclk_in), .fsync_in(fsync_in),
    .sample_in(sample_in), .sample_load(sample_load),
    .sdata(sdata), .sdata_oe(sdata_oe), .long_mode(long_mode)
  );

  // {pulse width in bit periods, sample}
  localparam logic [15:0] VEC [8] = '{
    {8'd1,  8'hA5}, {8'd2,  8'h3C}, {8'd3, 8'h81}, {8'd3, 8'hC3},
    {8'd10, 8'h5A}, {8'd1,  8'hFF}, {8'd12, 8'h96}, {8'd4, 8'h6B}
  };

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic half_check(int p, bit hi, int w, logic [7:0] s);
    bit on;
    int idx;
    if (model_long) begin
      on  = (p <= 6) || (p == 7 && hi) || (p < w);
      idx = 7 - p;
    end else begin
      on  = (p >= 1 && p <= 7) || (p == 8 && hi);
      idx = 8 - p;
    end
    // R3 R4 R6 R7 driver window
    check(model_long ? "R7 long window" : "R4 short window", {7'd0, sdata_oe}, {7'd0, on});
    if (on && idx >= 0 && idx <= 7)
      check("R2 bit order", {7'd0, sdata}, {7'd0, s[idx]});
  endtask

  task automatic run_frame(int w, logic [7:0] s, bit do_load, bit early,
                           bit midload, logic [7:0] nv);
    int np;
    np = ((w > 8) ? w : 9) + 1;
    if (do_load) begin
      @(negedge clk);
      sample_in = s; sample_load = 1'b1;
      @(negedge clk);
      sample_load = 1'b0;
    end
    @(negedge clk);
    if (early) begin
      repeat (4) @(negedge clk);
      fsync_in = 1'b1;
      repeat (3) @(negedge clk);
      check("R6 wait for bit clock", {7'd0, sdata_oe}, 8'd0);
      @(negedge clk);
    end
    for (int p = 0; p < np; p++) begin
      bclk_in = 1'b1;
      if (p == 0) fsync_in = 1'b1;
      if (p == w) fsync_in = 1'b0;
      repeat (6) @(negedge clk);
      half_check(p, 1'b1, w, s);
      if (midload && p == 3) begin
        sample_in = nv; sample_load = 1'b1;
      end
      @(negedge clk);
      sample_load = 1'b0;
      @(negedge clk);
      bclk_in = 1'b0;
      repeat (6) @(negedge clk);
      half_check(p, 1'b0, w, s);
      repeat (2) @(negedge clk);
    end
    model_long = (w >= 3);
    check("R5 mode flag", {7'd0, long_mode}, {7'd0, model_long});
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset enable", {7'd0, sdata_oe}, 8'd0);
    check("R1 reset mode", {7'd0, long_mode}, 8'd0);

    // R9 covered by the width-12 entry sent with short timing
    for (int i = 0; i < 8; i++)
      run_frame(int'(VEC[i][15:8]), VEC[i][7:0], 1'b1, 1'b0, 1'b0, 8'h00);

    // R6 sync rises during bit-clock low phase
    run_frame(4, 8'h2D, 1'b1, 1'b1, 1'b0, 8'h00);
    // R8 load during a frame affects only the next one
    run_frame(5, 8'hE1, 1'b1, 1'b0, 1'b1, 8'h47);
    run_frame(5, 8'h47, 1'b0, 1'b0, 1'b0, 8'h00);
    // back to short mode with a width-2 pulse, then a short frame
    run_frame(2, 8'h19, 1'b1, 1'b0, 1'b0, 8'h00);
    run_frame(1, 8'hC6, 1'b1, 1'b0, 1'b0, 8'h00);

    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule